// File: doc/BRIEF.md
# Converter Start and Phase Timing Sequencer

This block drives the timing of an analog-to-digital converter from a master clock. An 8-bit control register, loaded through a simple write port, selects a power mode, a converter clock divide ratio, the number of converter clocks spent tracking the input, and which start sources are enabled. The block divides the master clock into a converter clock strobe. When a start is accepted it runs a track (acquire) phase and then a conversion phase of a fixed number of converter clocks. At the end it raises a one-cycle done pulse and captures the converter's result word.

A start can come from three sources: a software request, every second pulse on a timer overflow input, or a low pulse on an external active-low start pin. The pin passes through a synchroniser and must stay low for a programmable number of master clocks before it counts. The power-down and standby outputs follow the selected power mode. In the two economy modes they are released only while a track or conversion cycle is running.

Top module: `cvt_timing_seq`

## Requirements
- R1: After reset the control register holds 0x20, so pdown_o is 1 and standby_o, track_o, convert_o, done_o and result_o are 0. The register is written only when bus_wr_i is high and bus_addr_i equals 0xEF. A write to any other address has no effect.
- R2: Control bits [5:4] choose the divide ratio N: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8. The counter restarts on an accepted start, and cvt_clk_en_o then pulses once every N master cycles, in cycles N, 2N, 3N and so on after the start edge.
- R3: Control bits [3:2] choose the track length A: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8 converter clocks. track_o is high for exactly A*N master cycles, starting in the cycle after the edge that accepts the start.
- R4: convert_o goes high in the cycle right after track_o falls and stays high for exactly 17*N master cycles.
- R5: done_o is high for one master cycle, the cycle after convert_o falls, which is cycle (A+17)*N+1 after the start edge. result_o takes the value cvt_data_i had at the edge that ends the conversion and holds it until the next done pulse.
- R6: A start from any source that arrives while track_o or convert_o is high is dropped. The cycle that is running keeps its length, and no second cycle follows it.
- R7: Control bits [7:6] set the power mode. 00 holds pdown_o high. 01 holds both pdown_o and standby_o low. 10 drives pdown_o high except while track_o or convert_o is high. 11 does the same with standby_o. In every mode the output that mode does not use stays low.
- R8: When control bit 1 is 1, pulses on tmr_ovf_i are counted and every second pulse is a start. The count is cleared while bit 1 is 0.
- R9: When control bit 0 is 1, cvt_start_ni passes through two synchronising flip-flops and must be seen low for QUAL_CYCLES consecutive master cycles. A pin low from cycle c for at least that long starts a cycle with track_o high from cycle c+QUAL_CYCLES+2. Shorter pulses are ignored, and a pin held low starts only one cycle.
- R10: When sw_start_i is high for one cycle in an idle, powered mode, a cycle starts, whatever bits 1 and 0 hold.
- R11: In power mode 00 every start source is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe for the control register |
| bus_addr_i | input | ADDR_W | Write address |
| bus_wdata_i | input | 8 | Write data |
| sw_start_i | input | 1 | Software start request, one cycle |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| cvt_start_ni | input | 1 | External start pin, active low, asynchronous |
| cvt_data_i | input | DATA_W | Result word from the converter |
| cvt_clk_en_o | output | 1 | Converter clock strobe, one master cycle wide |
| track_o | output | 1 | Track/acquire phase active |
| convert_o | output | 1 | Conversion phase active |
| done_o | output | 1 | One-cycle end-of-conversion pulse |
| pdown_o | output | 1 | Converter power-down request |
| standby_o | output | 1 | Converter standby request |
| result_o | output | DATA_W | Captured result word |

## Verification
The hardest cases to reach are the edges of start qualification. The external pin must be held low for exactly QUAL_CYCLES-1 and then QUAL_CYCLES cycles, and the cycle in which tracking begins has to be checked against the synchroniser and counter latency. The timer's pair counter also has to be caught half-way, with one overflow already seen, and then disabled and re-enabled. The bench reaches these by driving pulses of measured length at known cycle numbers. It interleaves single overflows with register writes, and it times each start from a free-running cycle counter. A sweep over all sixteen divide and track settings checks the phase lengths, the strobe count and the done cycle against arithmetic in the bench.

// File: rtl/cvt_seq_pkg.sv
package cvt_seq_pkg;

   typedef enum logic [1:0] {
      PH_IDLE    = 2'd0,
      PH_TRACK   = 2'd1,
      PH_CONVERT = 2'd2
   } phase_e;

   typedef enum logic [1:0] {
      PWR_OFF        = 2'b00,
      PWR_ON         = 2'b01,
      PWR_SLEEP_IDLE = 2'b10,
      PWR_STBY_IDLE  = 2'b11
   } pwr_mode_e;

   // bit order is the register layout: [7:6] power, [5:4] divide,
   // [3:2] track length, [1] timer start, [0] pin start
   typedef struct packed {
      pwr_mode_e  pwr;
      logic [1:0] div_sel;
      logic [1:0] acq_sel;
      logic       tmr_en;
      logic       pin_en;
   } ctrl_t;

   function automatic logic [3:0] sel_to_count(input logic [1:0] sel);
      return 4'd1 << sel;
   endfunction

endpackage

// File: rtl/cvt_ctrl_reg.sv
module cvt_ctrl_reg
   import cvt_seq_pkg::*;
#(
   parameter int                ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = 'hEF,
   parameter logic [7:0]        RST_VAL  = 8'h20
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [7:0]        wdata_i,
   output ctrl_t             ctrl_o
);

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("cvt_ctrl_reg: ADDR_W must be at least 1");
      end
   endgenerate

   logic  hit;
   ctrl_t ctrl_q;

   assign hit = wr_en_i && (addr_i == REG_ADDR);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q <= ctrl_t'(RST_VAL);
      end else if (hit) begin
         ctrl_q <= ctrl_t'(wdata_i);
      end
   end

   assign ctrl_o = ctrl_q;

   // R1: a write to another address leaves the register alone
   assert_miss_keeps_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i != REG_ADDR) |=> $stable(ctrl_q));

endmodule

// File: rtl/cvt_trig_unit.sv
module cvt_trig_unit
   import cvt_seq_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int QUAL_CYCLES = 13
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  pwr_mode_e pwr_i,
   input  logic      tmr_en_i,
   input  logic      pin_en_i,
   input  logic      sw_start_i,
   input  logic      tmr_ovf_i,
   input  logic      pin_start_ni,
   output logic      trig_o
);

   localparam int QW = $clog2(QUAL_CYCLES + 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("cvt_trig_unit: SYNC_STAGES must be at least 2");
      end
      if (QUAL_CYCLES < 1) begin : g_bad_qual
         $error("cvt_trig_unit: QUAL_CYCLES must be at least 1");
      end
   endgenerate

   // ---------------- pin synchroniser ----------------
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   pin_low;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sync_q <= '1;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_start_ni};
      end
   end

   assign pin_low = !sync_q[SYNC_STAGES-1];

   // ---------------- low-width qualifier ----------------
   logic qual_hit;

   generate
      if (QUAL_CYCLES == 1) begin : g_noqual
         assign qual_hit = pin_low;
      end else begin : g_qual
         logic [QW-1:0] low_cnt_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               low_cnt_q <= '0;
            end else if (!pin_low) begin
               low_cnt_q <= '0;
            end else if (low_cnt_q != QW'(QUAL_CYCLES - 1)) begin
               low_cnt_q <= low_cnt_q + 1'b1;
            end
         end
         assign qual_hit = pin_low && (low_cnt_q == QW'(QUAL_CYCLES - 1));
      end
   endgenerate

   logic fired_q;
   logic pin_fire;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         fired_q <= 1'b0;
      end else if (!pin_low) begin
         fired_q <= 1'b0;
      end else if (qual_hit) begin
         fired_q <= 1'b1;
      end
   end

   assign pin_fire = pin_en_i && qual_hit && !fired_q;

   // ---------------- overflow pair counter ----------------
   logic half_q;
   logic tmr_fire;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         half_q <= 1'b0;
      end else if (!tmr_en_i) begin
         half_q <= 1'b0;
      end else if (tmr_ovf_i) begin
         half_q <= !half_q;
      end
   end

   assign tmr_fire = tmr_en_i && tmr_ovf_i && half_q;

   assign trig_o = (pwr_i != PWR_OFF) && (sw_start_i || tmr_fire || pin_fire);

   // R9: a qualified low pulse yields a single start
   assert_pin_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pin_fire |=> !pin_fire);

   // R8: a timer start consumes the pair, so the next overflow cannot start
   assert_tmr_pair_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tmr_fire |=> !tmr_fire);

endmodule

// File: rtl/cvt_phase_seq.sv
module cvt_phase_seq
   import cvt_seq_pkg::*;
#(
   parameter int DATA_W    = 12,
   parameter int CONV_CLKS = 17
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [1:0]        div_sel_i,
   input  logic [1:0]        acq_sel_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              tick_o,
   output logic              track_o,
   output logic              convert_o,
   output logic              done_o,
   output logic              busy_o,
   output logic [DATA_W-1:0] result_o
);

   localparam int MAXV = (CONV_CLKS - 1 > 7) ? CONV_CLKS - 1 : 7;
   localparam int CW   = $clog2(MAXV + 1);

   generate
      if (CONV_CLKS < 2) begin : g_bad_conv
         $error("cvt_phase_seq: CONV_CLKS must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("cvt_phase_seq: DATA_W must be at least 1");
      end
   endgenerate

   phase_e            phase_q;
   logic [CW-1:0]     cnt_q;
   logic              done_q;
   logic [DATA_W-1:0] result_q;
   logic [2:0]        div_q;
   logic [2:0]        div_lim;
   logic [CW-1:0]     acq_last;
   logic              tick;
   logic              accept;

   assign div_lim  = 3'(sel_to_count(div_sel_i) - 4'd1);
   assign acq_last = CW'(sel_to_count(acq_sel_i) - 4'd1);
   assign tick     = (div_q >= div_lim);
   assign accept   = start_i && (phase_q == PH_IDLE);

   // converter clock divider, restarted by an accepted start
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         div_q <= '0;
      end else if (accept || tick) begin
         div_q <= '0;
      end else begin
         div_q <= div_q + 3'd1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q  <= PH_IDLE;
         cnt_q    <= '0;
         done_q   <= 1'b0;
         result_q <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (phase_q)
            PH_IDLE: begin
               if (start_i) begin
                  phase_q <= PH_TRACK;
                  cnt_q   <= '0;
               end
            end
            PH_TRACK: begin
               if (tick) begin
                  if (cnt_q >= acq_last) begin
                     phase_q <= PH_CONVERT;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            PH_CONVERT: begin
               if (tick) begin
                  if (cnt_q >= CW'(CONV_CLKS - 1)) begin
                     phase_q  <= PH_IDLE;
                     cnt_q    <= '0;
                     done_q   <= 1'b1;
                     result_q <= data_i;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign tick_o    = tick;
   assign track_o   = (phase_q == PH_TRACK);
   assign convert_o = (phase_q == PH_CONVERT);
   assign busy_o    = (phase_q != PH_IDLE);
   assign done_o    = done_q;
   assign result_o  = result_q;

   // R4: tracking always hands over to conversion
   assert_conv_follows_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(track_o) |-> convert_o);

   // R5: done is a single cycle right after conversion ends
   assert_done_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);
   assert_done_after_conv_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> ($past(convert_o) && !convert_o));

   // R6: a start during tracking does not disturb the running count
   assert_busy_ignores_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (track_o && start_i && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/cvt_timing_seq.sv
module cvt_timing_seq
   import cvt_seq_pkg::*;
#(
   parameter int                ADDR_W      = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR    = 'hEF,
   parameter logic [7:0]        RST_VAL     = 8'h20,
   parameter int                DATA_W      = 12,
   parameter int                CONV_CLKS   = 17,
   parameter int                SYNC_STAGES = 2,
   parameter int                QUAL_CYCLES = 13
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [7:0]        bus_wdata_i,
   input  logic              sw_start_i,
   input  logic              tmr_ovf_i,
   input  logic              cvt_start_ni,
   input  logic [DATA_W-1:0] cvt_data_i,
   output logic              cvt_clk_en_o,
   output logic              track_o,
   output logic              convert_o,
   output logic              done_o,
   output logic              pdown_o,
   output logic              standby_o,
   output logic [DATA_W-1:0] result_o
);

   ctrl_t ctrl;
   logic  trig;
   logic  busy;

   cvt_ctrl_reg #(
      .ADDR_W   (ADDR_W),
      .REG_ADDR (REG_ADDR),
      .RST_VAL  (RST_VAL)
   ) u_ctrl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (bus_wr_i),
      .addr_i  (bus_addr_i),
      .wdata_i (bus_wdata_i),
      .ctrl_o  (ctrl)
   );

   cvt_trig_unit #(
      .SYNC_STAGES (SYNC_STAGES),
      .QUAL_CYCLES (QUAL_CYCLES)
   ) u_trig (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .pwr_i        (ctrl.pwr),
      .tmr_en_i     (ctrl.tmr_en),
      .pin_en_i     (ctrl.pin_en),
      .sw_start_i   (sw_start_i),
      .tmr_ovf_i    (tmr_ovf_i),
      .pin_start_ni (cvt_start_ni),
      .trig_o       (trig)
   );

   cvt_phase_seq #(
      .DATA_W    (DATA_W),
      .CONV_CLKS (CONV_CLKS)
   ) u_seq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (trig),
      .div_sel_i (ctrl.div_sel),
      .acq_sel_i (ctrl.acq_sel),
      .data_i    (cvt_data_i),
      .tick_o    (cvt_clk_en_o),
      .track_o   (track_o),
      .convert_o (convert_o),
      .done_o    (done_o),
      .busy_o    (busy),
      .result_o  (result_o)
   );

   always_comb begin
      pdown_o   = 1'b0;
      standby_o = 1'b0;
      unique case (ctrl.pwr)
         PWR_OFF:        pdown_o   = 1'b1;
         PWR_ON:         ;
         PWR_SLEEP_IDLE: pdown_o   = !busy;
         PWR_STBY_IDLE:  standby_o = !busy;
         default:        pdown_o   = 1'b1;
      endcase
   end

   // R11: an idle block in the off mode stays idle
   assert_off_stays_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl.pwr == PWR_OFF && !busy) |=> !busy);

   // R5: every end of a cycle is marked by done
   assert_end_marked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy) |-> done_o);

   // R7: the two power requests are never raised together
   assert_power_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(pdown_o && standby_o));

endmodule

// File: tb/test_cvt_timing_seq.sv
module test_cvt_timing_seq;

   localparam int DW = 12;
   localparam int Q  = 13;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [7:0]    bus_addr = 8'h00;
   logic [7:0]    bus_wdata = 8'h00;
   logic          sw_start = 1'b0;
   logic          tmr_ovf = 1'b0;
   logic          pin_n = 1'b1;
   logic [DW-1:0] cvt_data = '0;
   logic          clk_en, track, convert, done, pdown, standby;
   logic [DW-1:0] result;

   always #4 clk = ~clk;

   cvt_timing_seq #(.DATA_W(DW), .QUAL_CYCLES(Q)) i_cvt_timing_seq (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .bus_wr_i     (bus_wr),
      .bus_addr_i   (bus_addr),
      .bus_wdata_i  (bus_wdata),
      .sw_start_i   (sw_start),
      .tmr_ovf_i    (tmr_ovf),
      .cvt_start_ni (pin_n),
      .cvt_data_i   (cvt_data),
      .cvt_clk_en_o (clk_en),
      .track_o      (track),
      .convert_o    (convert),
      .done_o       (done),
      .pdown_o      (pdown),
      .standby_o    (standby),
      .result_o     (result)
   );

   int cyc = 0;
   int starts = 0;
   int last_rise = 0;
   logic trk_prev = 1'b0;
   int n_run = 0;
   int n_fail = 0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n && track && !trk_prev) begin
         starts    = starts + 1;
         last_rise = cyc;
      end
      trk_prev = track;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic ovf_pulse();
      @(negedge clk);
      tmr_ovf = 1'b1;
      @(negedge clk);
      tmr_ovf = 1'b0;
   endtask

   task automatic pin_low(input int len);
      @(negedge clk);
      pin_n = 1'b0;
      wait_n(len);
      pin_n = 1'b1;
   endtask

   // one software-started cycle, measured phase by phase
   task automatic run_cfg(input logic [1:0] mode, input logic [1:0] dv,
                          input logic [1:0] aq, input int retrig_at);
      int n, a, t, trk, cnv, stb, dn, didx, bad, s0;
      logic [DW-1:0] dat;
      n = 1 << dv; a = 1 << aq; t = (a + 17) * n;
      trk = 0; cnv = 0; stb = 0; dn = 0; didx = 0; bad = 0;
      dat = DW'(12'h5A1 + dv * 16 + aq * 3);
      wr(8'hEF, {mode, dv, aq, 2'b00});
      cvt_data = dat;
      s0 = starts;
      @(negedge clk);
      sw_start = 1'b1;
      @(negedge clk);
      sw_start = 1'b0;
      for (int i = 1; i <= t + 3; i++) begin
         if (track) trk++;
         if (convert) cnv++;
         if (clk_en && i <= t) stb++;
         if (done) begin dn++; didx = i; end
         if (mode == 2'b10 && (pdown != !(i <= t) || standby)) bad++;
         if (mode == 2'b11 && (standby != !(i <= t) || pdown)) bad++;
         if (i == retrig_at) sw_start = 1'b1;
         if (i == retrig_at + 1) sw_start = 1'b0;
         if (i == t + 1) cvt_data = ~dat;
         @(negedge clk);
      end
      chk(trk == a * n, "R3 track length", trk, a * n);
      chk(cnv == 17 * n, "R4 convert length", cnv, 17 * n);
      chk(stb == a + 17, "R2 strobe count", stb, a + 17);
      chk(dn == 1 && didx == t + 1, "R5 done cycle", didx, t + 1);
      chk(result == dat, "R5 result", int'(result), int'(dat));
      if (retrig_at > 0) chk(starts - s0 == 1, "R6 busy start dropped", starts - s0, 1);
      else chk(starts - s0 == 1, "R10 software start", starts - s0, 1);
      if (mode[1]) chk(bad == 0, "R7 power follows busy", bad, 0);
   endtask

   initial begin
      int s0, c0;
      wait_n(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(pdown == 1'b1, "R1 reset pdown", int'(pdown), 1);
      chk({standby, track, convert, done} == 4'b0, "R1 reset outputs",
          int'({standby, track, convert, done}), 0);
      chk(result == '0, "R1 reset result", int'(result), 0);

      // R1 wrong address ignored, R11 off mode ignores software start
      wr(8'hEE, 8'h40);
      s0 = starts;
      @(negedge clk); sw_start = 1'b1; @(negedge clk); sw_start = 1'b0;
      wait_n(40);
      chk(starts == s0 && pdown, "R1 miss write ignored", starts - s0, 0);

      // R11 all sources in off mode
      wr(8'hEF, 8'h03);
      s0 = starts;
      @(negedge clk); sw_start = 1'b1; @(negedge clk); sw_start = 1'b0;
      ovf_pulse(); ovf_pulse();
      pin_low(30);
      wait_n(40);
      chk(starts == s0, "R11 off mode ignores", starts - s0, 0);
      chk(pdown == 1'b1, "R11 off mode pdown", int'(pdown), 1);

      // R7 normal mode
      wr(8'hEF, 8'h40);
      @(negedge clk);
      chk(!pdown && !standby, "R7 normal mode outputs", int'({pdown, standby}), 0);

      // R2 R3 R4 R5 R10 sweep
      for (int dv = 0; dv < 4; dv++)
         for (int aq = 0; aq < 4; aq++)
            run_cfg(2'b01, 2'(dv), 2'(aq), 0);

      // R7 economy modes
      run_cfg(2'b10, 2'b01, 2'b10, 0);
      run_cfg(2'b11, 2'b10, 2'b00, 0);

      // R6 starts while busy
      run_cfg(2'b01, 2'b01, 2'b01, 3);
      run_cfg(2'b01, 2'b01, 2'b01, 30);

      // R8 timer pairs
      wr(8'hEF, 8'h42);
      s0 = starts;
      ovf_pulse();
      wait_n(30);
      chk(starts == s0, "R8 first overflow no start", starts - s0, 0);
      @(negedge clk); tmr_ovf = 1'b1;
      @(negedge clk); tmr_ovf = 1'b0;
      chk(track == 1'b1, "R8 second overflow starts", int'(track), 1);
      wait_n(30);
      s0 = starts;
      ovf_pulse();
      wr(8'hEF, 8'h40);
      wr(8'hEF, 8'h42);
      ovf_pulse();
      wait_n(30);
      chk(starts == s0, "R8 disable clears pair", starts - s0, 0);
      ovf_pulse();
      wait_n(30);
      chk(starts == s0 + 1, "R8 pair after clear", starts - s0, 1);

      // R9 external pin
      wr(8'hEF, 8'h41);
      s0 = starts;
      pin_low(Q - 1);
      wait_n(40);
      chk(starts == s0, "R9 short pulse ignored", starts - s0, 0);
      @(negedge clk);
      c0 = cyc;
      pin_n = 1'b0;
      wait_n(Q);
      pin_n = 1'b1;
      wait_n(40);
      chk(starts == s0 + 1, "R9 qualified pulse starts", starts - s0, 1);
      chk(last_rise == c0 + Q + 2, "R9 start latency", last_rise - c0, Q + 2);
      s0 = starts;
      pin_low(100);
      wait_n(30);
      chk(starts == s0 + 1, "R9 held pin one start", starts - s0, 1);
      wr(8'hEF, 8'h40);
      s0 = starts;
      pin_low(30);
      wait_n(30);
      chk(starts == s0, "R9 pin disabled ignored", starts - s0, 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(8 * 200000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule